// File: doc/BRIEF.md
# EDO DRAM Module Controller

A synchronous controller that connects a simple host request port to a 36-bit EDO DRAM module built from four byte lanes. Each lane holds eight data bits and one parity bit, and each lane has its own column strobe. The host presents a 22-bit word address, a write flag, four byte enables and 36 bits of write data. The controller splits the address into a 12-bit row phase and a column phase. It sequences one row strobe, the four lane column strobes and a write-enable so that each access is a single early write or a single read. Parity bits travel with their lane and are neither generated nor checked.

After reset the controller keeps the host blocked through a start-up pause, then runs eight refresh cycles. After that it runs a column-before-row refresh once per refresh interval. A pending refresh is served before any new host request. Every DRAM timing is a parameter counted in controller clock cycles. The defaults assume a 100 MHz clock and the 60 ns speed grade.

Top module: `edo_dram_ctrl`

## Requirements
- R1: On the cycle the row strobe falls for a host access, `dram_addr` equals `host_addr[21:10]`. On the cycle the column strobes fall, `dram_addr` equals `{2'b00, host_addr[9:0]}`.
- R2: After reset, all strobes are inactive (`dram_ras_n`=1, `dram_cas_n`=4'hF, `dram_we_n`=1, `dram_dq_oe`=0) and `host_ack` and `host_rvalid` are low. No row strobe falls for T_INIT cycles. Exactly 8 refresh cycles then precede the first host access.
- R3: A refresh drives all four column strobes low at least T_CSR cycles before the row strobe falls, with `dram_we_n` high. Column strobes are never low while the row strobe is high except in this form.
- R4: After initialisation, consecutive refresh cycles are never more than T_REFI plus one access length apart, even under back-to-back host traffic. A pending refresh wins over a host request.
- R5: The row strobe stays high for at least T_RP cycles between activations. It stays low for at least T_RAS cycles. A full cycle spans at least T_RC cycles.
- R6: For a host access the row strobe falls while all column strobes are high. The column strobes fall no earlier than T_RCD cycles after the row strobe.
- R7: A write is an early write. `dram_we_n` is low and `dram_dq_out` is driven (`dram_dq_oe`=1) before and while the column strobes fall. Lanes whose enable is 0 are not written, and a write with `host_be`=0 drops no column strobe.
- R8: A read drops all four column strobes with `dram_dq_oe`=0. `host_rdata` returns `dram_dq_in` sampled T_CAC cycles after the column strobes fall. `host_rvalid` is a single-cycle pulse.
- R9: Lane i is bits [9i+8:9i] of the data bus, with bit 9i+8 its parity bit. `host_be[i]` controls `dram_cas_n[i]` (1 = lane written), and parity bits are stored and returned unchanged.
- R10: `host_ack` is a single-cycle pulse, one cycle after the host request is accepted. The host holds `host_req` and its request fields until it sees `host_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Access request, held until acknowledged |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 22 | Word address |
| host_be | input | 4 | Lane enables for writes |
| host_wdata | input | 36 | Write data, four 9-bit lanes |
| host_ack | output | 1 | Request accepted pulse |
| host_rvalid | output | 1 | Read data valid pulse |
| host_rdata | output | 36 | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 4 | Per-lane column strobes, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_dq_out | output | 36 | Data driven to the module |
| dram_dq_oe | output | 1 | Output enable for `dram_dq_out` |
| dram_dq_in | input | 36 | Data returned by the module |

## Verification
The bound checker watches the strobe rules on every cycle. It checks the minimum row precharge and row active widths, the column-before-row ordering with write-enable high, the row-to-column delay, early-write ordering, and the single-cycle acknowledge and read-valid pulses. Other behaviour can only be shown by the bench's scenarios, running against a behavioural DRAM model and a scoreboard of expected read data. These include the correct row and column split of addresses, merging of masked lanes and parity bits into stored words, and the start-up pause with exactly eight refreshes. They also include the bound on refresh spacing under sustained traffic.

// File: rtl/edo_pkg.sv
// Package: shared state encoding and integer helpers for the EDO controller.
// Assumes: all users import it before declaring parameters that depend on it.
package edo_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // row strobe high, waiting for refresh or host work
        ST_ACT,    // row strobe low, row address on the bus
        ST_COL,    // column strobes low, column address on the bus
        ST_RSET,   // refresh: column strobes low ahead of row strobe
        ST_RACT,   // refresh: row strobe low
        ST_PRE     // row precharge
    } seq_st_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/edo_refresh_sched.sv
// Module: refresh scheduler.
// What it does: holds off host traffic for T_INIT cycles after reset. It then
// raises a refresh request N_INIT_REF times. After that it raises one request
// every T_REFI cycles.
// Assumes: ref_start pulses once per refresh issued by the sequencer, and the
// sequencer serves a request within T_REFI cycles.
module edo_refresh_sched #(
    parameter int T_INIT     = 20000,
    parameter int T_REFI     = 1560,
    parameter int N_INIT_REF = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_start,
    output logic ref_pend,
    output logic init_done
);
    localparam int PW = $clog2(T_INIT + 1);
    localparam int RW = $clog2(T_REFI + 1);
    localparam int IW = $clog2(N_INIT_REF + 1);

    logic [PW-1:0] pause_cnt;
    logic          pause_done;
    logic [IW-1:0] init_left;
    logic [RW-1:0] refi_cnt;
    logic          per_pend;

    // Start-up pause counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pause_cnt  <= '0;
            pause_done <= 1'b0;
        end else if (!pause_done) begin
            if (pause_cnt == PW'(T_INIT - 1)) pause_done <= 1'b1;
            else                              pause_cnt  <= pause_cnt + 1'b1;
        end
    end

    // Count down the initial dummy refreshes.
    always_ff @(posedge clk) begin
        if (!rst_n)                              init_left <= IW'(N_INIT_REF);
        else if (ref_start && init_left != '0)   init_left <= init_left - 1'b1;
    end

    // Periodic interval timer and its pending flag. A new tick wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            refi_cnt <= '0;
            per_pend <= 1'b0;
        end else if (init_done) begin
            if (ref_start) per_pend <= 1'b0;
            if (refi_cnt == RW'(T_REFI - 1)) begin
                refi_cnt <= '0;
                per_pend <= 1'b1;
            end else begin
                refi_cnt <= refi_cnt + 1'b1;
            end
        end
    end

    assign init_done = pause_done && (init_left == '0);
    assign ref_pend  = pause_done && ((init_left != '0) || per_pend);

endmodule

// File: rtl/edo_lane_strobe.sv
// Module: per-lane column strobe gating.
// What it does: turns the sequencer's column-active flag and lane mask into
// active-low strobes, one per lane.
// Assumes: both inputs come straight from registers, so the strobes change
// only just after a clock edge.
module edo_lane_strobe #(
    parameter int LANES = 4
) (
    input  logic             cas_on,
    input  logic [LANES-1:0] lane_en,
    output logic [LANES-1:0] cas_n
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // One active-low strobe per lane.
        assign cas_n[i] = ~(cas_on & lane_en[i]);
    end
endmodule

// File: rtl/edo_seq.sv
// Module: access and refresh sequencer.
// What it does: one state machine with a single down-counter. It runs the
// column-before-row refresh and single early-write or read accesses, and
// latches read data T_CAC cycles after the column strobes fall.
// Assumes: the host holds its request fields until ack; timing parameters >= 1.
module edo_seq
    import edo_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int ROW_W  = 12,
    parameter int LANES  = 4,
    parameter int DQ_W   = 36,
    parameter int T_RP   = 4,
    parameter int T_RAS  = 6,
    parameter int T_RC   = 11,
    parameter int T_RCD  = 2,
    parameter int T_CAS  = 1,
    parameter int T_CAC  = 2,
    parameter int T_CSR  = 1,
    parameter int T_CHR  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  be,
    input  logic [DQ_W-1:0]   wdata,
    input  logic              ref_pend,
    input  logic              init_done,
    input  logic [DQ_W-1:0]   dq_in,
    output logic              ack,
    output logic              ref_start,
    output logic              ras_n,
    output logic              cas_on,
    output logic [LANES-1:0]  lane_en,
    output logic              we_n,
    output logic [ROW_W-1:0]  dram_addr,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe,
    output logic              rvalid,
    output logic [DQ_W-1:0]   rdata
);
    localparam int COL_W   = ADDR_W - ROW_W;
    localparam int COL_LEN = imax(imax(T_CAS, T_CAC), T_RAS - T_RCD);
    localparam int REF_LOW = imax(T_RAS, T_CHR);
    localparam int LOW_MIN = imin(T_RCD + COL_LEN, REF_LOW);
    localparam int PRE_LEN = imax(T_RP, T_RC - LOW_MIN);
    localparam int MAXLEN  = imax(imax(COL_LEN, PRE_LEN), imax(imax(T_RCD, T_CSR), REF_LOW));
    localparam int TMR_W   = $clog2(MAXLEN + 1);

    seq_st_t          state;
    logic [TMR_W-1:0] tmr;
    logic             is_wr;
    logic [COL_W-1:0] col_q;

    // Main sequencer: state, countdown and all registered DRAM-side outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            tmr       <= '0;
            is_wr     <= 1'b0;
            col_q     <= '0;
            ras_n     <= 1'b1;
            cas_on    <= 1'b0;
            lane_en   <= '0;
            we_n      <= 1'b1;
            dram_addr <= '0;
            dq_out    <= '0;
            dq_oe     <= 1'b0;
            ack       <= 1'b0;
            ref_start <= 1'b0;
            rvalid    <= 1'b0;
            rdata     <= '0;
        end else begin
            ack       <= 1'b0;
            ref_start <= 1'b0;
            rvalid    <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (ref_pend) begin
                        state     <= ST_RSET;
                        tmr       <= TMR_W'(T_CSR - 1);
                        cas_on    <= 1'b1;
                        lane_en   <= '1;
                        we_n      <= 1'b1;
                        ref_start <= 1'b1;
                    end else if (req && init_done) begin
                        state     <= ST_ACT;
                        tmr       <= TMR_W'(T_RCD - 1);
                        ack       <= 1'b1;
                        is_wr     <= we;
                        col_q     <= addr[COL_W-1:0];
                        ras_n     <= 1'b0;
                        dram_addr <= addr[ADDR_W-1 -: ROW_W];
                        we_n      <= ~we;
                        dq_out    <= wdata;
                        dq_oe     <= we;
                        lane_en   <= we ? be : '1;
                    end
                end
                ST_ACT: begin
                    if (tmr == '0) begin
                        state     <= ST_COL;
                        tmr       <= TMR_W'(COL_LEN - 1);
                        cas_on    <= 1'b1;
                        dram_addr <= ROW_W'(col_q);
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                ST_COL: begin
                    if (!is_wr && tmr == TMR_W'(COL_LEN - T_CAC)) begin
                        rdata  <= dq_in;
                        rvalid <= 1'b1;
                    end
                    if (tmr == '0) begin
                        state  <= ST_PRE;
                        tmr    <= TMR_W'(PRE_LEN - 1);
                        ras_n  <= 1'b1;
                        cas_on <= 1'b0;
                        we_n   <= 1'b1;
                        dq_oe  <= 1'b0;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                ST_RSET: begin
                    if (tmr == '0) begin
                        state <= ST_RACT;
                        tmr   <= TMR_W'(REF_LOW - 1);
                        ras_n <= 1'b0;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                ST_RACT: begin
                    if (tmr == '0) begin
                        state  <= ST_PRE;
                        tmr    <= TMR_W'(PRE_LEN - 1);
                        ras_n  <= 1'b1;
                        cas_on <= 1'b0;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                ST_PRE: begin
                    if (tmr == '0) state <= ST_IDLE;
                    else           tmr   <= tmr - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/edo_dram_ctrl.sv
// Module: EDO DRAM module controller, top level.
// What it does: ties the refresh scheduler, the sequencer and the lane strobe
// gating together behind a request/ack host port.
// Assumes: timing parameters are in clock cycles (defaults: 100 MHz, 60 ns
// grade); DQ_W = LANES * LANE_W, and each lane's top bit is its parity bit.
module edo_dram_ctrl #(
    parameter int ADDR_W     = 22,
    parameter int ROW_W      = 12,
    parameter int LANES      = 4,
    parameter int LANE_W     = 9,
    parameter int T_INIT     = 20000,
    parameter int T_REFI     = 1560,
    parameter int N_INIT_REF = 8,
    parameter int T_RP       = 4,
    parameter int T_RAS      = 6,
    parameter int T_RC       = 11,
    parameter int T_RCD      = 2,
    parameter int T_CAS      = 1,
    parameter int T_CAC      = 2,
    parameter int T_CSR      = 1,
    parameter int T_CHR      = 1,
    localparam int DQ_W      = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [LANES-1:0]  host_be,
    input  logic [DQ_W-1:0]   host_wdata,
    output logic              host_ack,
    output logic              host_rvalid,
    output logic [DQ_W-1:0]   host_rdata,
    output logic              dram_ras_n,
    output logic [LANES-1:0]  dram_cas_n,
    output logic              dram_we_n,
    output logic [ROW_W-1:0]  dram_addr,
    output logic [DQ_W-1:0]   dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DQ_W-1:0]   dram_dq_in
);
    logic             ref_start, ref_pend, init_done, cas_on;
    logic [LANES-1:0] lane_en;

    edo_refresh_sched #(
        .T_INIT(T_INIT), .T_REFI(T_REFI), .N_INIT_REF(N_INIT_REF)
    ) sched_i (
        .clk(clk), .rst_n(rst_n), .ref_start(ref_start),
        .ref_pend(ref_pend), .init_done(init_done)
    );

    edo_seq #(
        .ADDR_W(ADDR_W), .ROW_W(ROW_W), .LANES(LANES), .DQ_W(DQ_W),
        .T_RP(T_RP), .T_RAS(T_RAS), .T_RC(T_RC), .T_RCD(T_RCD),
        .T_CAS(T_CAS), .T_CAC(T_CAC), .T_CSR(T_CSR), .T_CHR(T_CHR)
    ) seq_i (
        .clk(clk), .rst_n(rst_n),
        .req(host_req), .we(host_we), .addr(host_addr), .be(host_be),
        .wdata(host_wdata), .ref_pend(ref_pend), .init_done(init_done),
        .dq_in(dram_dq_in), .ack(host_ack), .ref_start(ref_start),
        .ras_n(dram_ras_n), .cas_on(cas_on), .lane_en(lane_en),
        .we_n(dram_we_n), .dram_addr(dram_addr), .dq_out(dram_dq_out),
        .dq_oe(dram_dq_oe), .rvalid(host_rvalid), .rdata(host_rdata)
    );

    edo_lane_strobe #(.LANES(LANES)) strobe_i (
        .cas_on(cas_on), .lane_en(lane_en), .cas_n(dram_cas_n)
    );

endmodule

// File: rtl/edo_dram_ctrl_chk.sv
// Module: protocol checker bound to edo_dram_ctrl.
// What it does: counts strobe high/low run lengths and checks the DRAM strobe
// rules and host pulse shapes on every cycle.
// Assumes: the same timing parameters as the bound controller instance.
module edo_dram_ctrl_chk #(
    parameter int LANES = 4,
    parameter int T_RP  = 4,
    parameter int T_RAS = 6,
    parameter int T_RCD = 2,
    parameter int T_CSR = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ras_n,
    input logic [LANES-1:0] cas_n,
    input logic             we_n,
    input logic             dq_oe,
    input logic             req,
    input logic             ack,
    input logic             rvalid
);
    logic [15:0] hi_cnt, lo_cnt, cas_lo_cnt;

    // Run-length counters of row strobe high, row strobe low and all-lanes-low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt     <= '0;
            lo_cnt     <= '0;
            cas_lo_cnt <= '0;
        end else begin
            hi_cnt     <= ras_n ? ((hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 1'b1) : '0;
            lo_cnt     <= !ras_n ? ((lo_cnt == 16'hFFFF) ? lo_cnt : lo_cnt + 1'b1) : '0;
            cas_lo_cnt <= (cas_n == '0) ? ((cas_lo_cnt == 16'hFFFF) ? cas_lo_cnt : cas_lo_cnt + 1'b1) : '0;
        end
    end

    assert_ras_precharge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (hi_cnt >= 16'(T_RP)));

    assert_ras_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (lo_cnt >= 16'(T_RAS)));

    assert_cbr_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && cas_n != '1) |-> (cas_n == '0 && we_n && cas_lo_cnt >= 16'(T_CSR)));

    assert_cas_without_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n && cas_n != '1) |-> (cas_n == '0 && we_n && !dq_oe));

    assert_access_rcd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && cas_n != '1 && $past(cas_n) == '1) |-> (lo_cnt >= 16'(T_RCD)));

    assert_early_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && cas_n != '1 && $past(cas_n) == '1 && !we_n) |-> ($past(!we_n) && dq_oe));

    assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    assert_ack_after_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(req));

    assert_rvalid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);

endmodule

bind edo_dram_ctrl edo_dram_ctrl_chk #(
    .LANES(LANES), .T_RP(T_RP), .T_RAS(T_RAS), .T_RCD(T_RCD), .T_CSR(T_CSR)
) chk_i (
    .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
    .we_n(dram_we_n), .dq_oe(dram_dq_oe), .req(host_req), .ack(host_ack),
    .rvalid(host_rvalid)
);

// File: tb/edo_dram_ctrl_tb_top.sv
// Bench: behavioural DRAM model plus read scoreboard for edo_dram_ctrl.
module edo_dram_ctrl_tb_top;
    localparam int T_INIT = 200;
    localparam int T_REFI = 300;
    localparam int SLACK  = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [21:0] host_addr = '0;
    logic [3:0]  host_be = '0;
    logic [35:0] host_wdata = '0;
    logic        host_ack, host_rvalid;
    logic [35:0] host_rdata;
    logic        dram_ras_n, dram_we_n, dram_dq_oe;
    logic [3:0]  dram_cas_n;
    logic [11:0] dram_addr;
    logic [35:0] dram_dq_out;
    logic [35:0] dram_dq_in = '0;

    always #2 clk = ~clk;

    edo_dram_ctrl #(.T_INIT(T_INIT), .T_REFI(T_REFI)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_be(host_be), .host_wdata(host_wdata),
        .host_ack(host_ack), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_addr(dram_addr), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
        .dram_dq_in(dram_dq_in)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    typedef struct packed { logic wr; logic [21:0] a; logic [3:0] be; } acc_t;
    acc_t        acc_q[$];
    logic [35:0] rd_q[$];
    logic [35:0] exp_mem[int];
    logic [35:0] mem[int];

    function automatic logic [35:0] rd_mem(input logic [21:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : 36'h0;
    endfunction
    function automatic logic [35:0] rd_exp(input logic [21:0] a);
        return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 36'h0;
    endfunction

    // DRAM model: edge detection on the strobes, row/column capture, storage.
    logic        p_ras = 1'b1;
    logic [3:0]  p_cas = 4'hF;
    logic [11:0] row_q = '0;
    logic [21:0] a_cur = '0;
    acc_t        cur;
    bit          in_acc = 1'b0, cas_seen = 1'b0, first_acc = 1'b1;
    int          cyc = 0, init_cbr = 0, last_cbr = 0, n_cbr = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            cyc <= 0; p_ras <= 1'b1; p_cas <= 4'hF; dram_dq_in <= '0;
        end else begin
            logic [21:0] a;
            logic [35:0] w;
            cyc   <= cyc + 1;
            p_ras <= dram_ras_n;
            p_cas <= dram_cas_n;
            dram_dq_in <= '0;
            if (p_ras && !dram_ras_n) begin
                if (dram_cas_n == 4'h0) begin
                    // refresh row strobe fall
                    n_cbr++;
                    if (first_acc) init_cbr++;
                    else begin
                        chk(cyc - last_cbr <= T_REFI + SLACK, "R4 refresh spacing", 64'(cyc - last_cbr), 64'(T_REFI + SLACK));
                    end
                    last_cbr <= cyc;
                end else begin
                    if (first_acc) begin
                        chk(init_cbr == 8, "R2 init refresh count", 64'(init_cbr), 64'd8);
                        chk(cyc >= T_INIT, "R2 init pause", 64'(cyc), 64'(T_INIT));
                        first_acc <= 1'b0;
                    end
                    chk(acc_q.size() != 0, "R10 access without request", 64'(acc_q.size()), 64'd1);
                    if (acc_q.size() != 0) cur = acc_q.pop_front();
                    chk(dram_addr == cur.a[21:10], "R1 row address", 64'(dram_addr), 64'(cur.a[21:10]));
                    row_q    <= dram_addr;
                    in_acc   <= 1'b1;
                    cas_seen <= 1'b0;
                end
            end
            if (!dram_ras_n && p_cas == 4'hF && dram_cas_n != 4'hF && in_acc) begin
                a = {row_q, dram_addr[9:0]};
                a_cur    <= a;
                cas_seen <= 1'b1;
                chk(dram_addr == {2'b00, cur.a[9:0]}, "R1 column address", 64'(dram_addr), 64'({2'b00, cur.a[9:0]}));
                if (cur.wr) begin
                    chk(dram_cas_n == ~cur.be, "R9 lane strobes follow byte enables", 64'(dram_cas_n), 64'(~cur.be));
                    chk(!dram_we_n && dram_dq_oe, "R7 early write controls", 64'({dram_we_n, dram_dq_oe}), 64'b01);
                    w = rd_mem(a);
                    for (int i = 0; i < 4; i++)
                        if (!dram_cas_n[i]) w[9*i +: 9] = dram_dq_out[9*i +: 9];
                    mem[int'(a)] = w;
                end else begin
                    chk(dram_cas_n == 4'h0 && dram_we_n && !dram_dq_oe, "R8 read strobes", 64'({dram_cas_n, dram_we_n, dram_dq_oe}), 64'b000010);
                    dram_dq_in <= rd_mem(a);
                end
            end else if (!dram_ras_n && dram_cas_n == 4'h0 && dram_we_n && in_acc) begin
                dram_dq_in <= rd_mem(a_cur);
            end
            if (!p_ras && dram_ras_n && in_acc) begin
                in_acc <= 1'b0;
                if (cur.wr && cur.be == 4'h0)
                    chk(!cas_seen, "R7 empty write drops no strobe", 64'(cas_seen), 64'd0);
            end
        end
    end

    // Scoreboard monitor: compare returned read data against expected queue.
    always @(negedge clk) begin
        if (rst_n && host_rvalid) begin
            chk(rd_q.size() != 0, "R8 unexpected rvalid", 64'(rd_q.size()), 64'd1);
            if (rd_q.size() != 0) begin
                logic [35:0] e;
                e = rd_q.pop_front();
                chk(host_rdata == e, "R8/R9 read data", 64'(host_rdata), 64'(e));
            end
        end
    end

    // Driver: one host access; pushes expectations when acknowledged.
    task automatic host_op(input logic w, input logic [21:0] a, input logic [3:0] b, input logic [35:0] d);
        acc_t t;
        logic [35:0] m;
        @(negedge clk);
        host_req = 1'b1; host_we = w; host_addr = a; host_be = b; host_wdata = d;
        do @(negedge clk); while (!host_ack);
        host_req = 1'b0;
        t.wr = w; t.a = a; t.be = b;
        acc_q.push_back(t);
        if (w) begin
            m = rd_exp(a);
            for (int i = 0; i < 4; i++) if (b[i]) m[9*i +: 9] = d[9*i +: 9];
            exp_mem[int'(a)] = m;
        end else begin
            rd_q.push_back(rd_exp(a));
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        repeat (3) @(negedge clk);
        chk(dram_ras_n && dram_cas_n == 4'hF && dram_we_n && !dram_dq_oe, "R2 reset strobes",
            64'({dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe}), 64'b1111110);
        chk(!host_ack && !host_rvalid, "R2 reset host outputs", 64'({host_ack, host_rvalid}), 64'd0);
        rst_n = 1'b1;
        // R2 / R10: a request during initialisation waits for the 8 refreshes.
        host_op(1'b1, 22'h000000, 4'hF, 36'h1_2345_6789);
        host_op(1'b0, 22'h000000, 4'h0, '0);
        // R9: parity-only pattern, all lanes.
        host_op(1'b1, 22'h3FFFFF, 4'hF, 36'h8_0402_0100);
        host_op(1'b0, 22'h3FFFFF, 4'h0, '0);
        // R7 / R9: partial lane writes merge into the stored word.
        host_op(1'b1, 22'h155AAA, 4'hF, 36'hF_FFFF_FFFF);
        host_op(1'b1, 22'h155AAA, 4'b0101, 36'h0_0000_0000);
        host_op(1'b0, 22'h155AAA, 4'h0, '0);
        host_op(1'b1, 22'h155AAA, 4'b1000, 36'hA_5000_0000);
        host_op(1'b0, 22'h155AAA, 4'h0, '0);
        // R7: write with no lanes enabled leaves the word untouched.
        host_op(1'b1, 22'h155AAA, 4'h0, 36'h0_0000_0000);
        host_op(1'b0, 22'h155AAA, 4'h0, '0);
        // R1: row-only and column-only address differences.
        host_op(1'b1, 22'h000400, 4'hF, 36'h0_0000_0ABC);
        host_op(1'b1, 22'h000001, 4'hF, 36'h0_0000_0DEF);
        host_op(1'b0, 22'h000400, 4'h0, '0);
        host_op(1'b0, 22'h000001, 4'h0, '0);
        // R4: sustained back-to-back traffic across several refresh intervals.
        for (int k = 0; k < 160; k++) begin
            logic [21:0] a;
            a = 22'(k * 37 + 22'h2_0000);
            host_op(1'b1, a, 4'(k), 36'(k * 64'h1_0101_0101));
            host_op(1'b0, a, 4'h0, '0);
        end
        repeat (2 * T_REFI) @(negedge clk);
        chk(rd_q.size() == 0, "R8 all reads returned", 64'(rd_q.size()), 64'd0);
        chk(cyc - last_cbr <= T_REFI + SLACK, "R4 refresh continues when idle", 64'(cyc - last_cbr), 64'(T_REFI + SLACK));
        chk(n_cbr >= 8 + (cyc - T_INIT) / (T_REFI + SLACK), "R4 refresh count", 64'(n_cbr), 64'(8 + (cyc - T_INIT) / (T_REFI + SLACK)));
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule